// File: doc/BRIEF.md
# Restart Vector Interrupt Controller

This block sits beside an 8-bit processor. It gathers up to eight interrupt request lines into a pending register and raises a single interrupt line towards the processor. When the processor fetches the interrupt response byte, the block puts a one-byte restart call instruction on the data bus. That instruction sends the processor to a handler at eight times the serviced request's index. The winner is the lowest-numbered request that is both pending and enabled. Its pending bit is dropped as the response byte is read.

The processor marks a response fetch through its status byte. When `stat_stb` is high, the block samples bit 0 of that byte on `stat_d0`. A high bit opens an acknowledge window, and the block freezes its choice of request at that clock. The next read strobe then takes the byte. The window closes when the read strobe falls or when another status byte arrives. The read data path follows the processor's own strobe timing and has no back-pressure, so it stays a plain bus port with an output enable rather than a valid/ready stream.

Top module: `rst_vec_intc`

## Requirements
- R1: After reset, the pending register is empty, `int_out` is low, `d_oe` is low and `d_out` is 8'h00.
- R2: A rising edge on `irq_req[i]`, seen at a clock edge, sets pending bit i. The bit stays set until it is serviced. A line that is held high does not set the bit again after it has been serviced.
- R3: `int_out` is high exactly when `cpu_inte` is high and at least one pending bit has its `irq_en` bit set. Pending bits that are masked do not raise `int_out`.
- R4: A clock with `stat_stb` high and `stat_d0` high opens an acknowledge window and freezes the selected request. Requests that arrive after that clock do not change the byte driven in that window.
- R5: Among requests that are both pending and enabled, index 0 has the highest priority and index 7 the lowest.
- R6: The byte driven is the restart opcode {2'b11, idx[2:0], 3'b111}, which calls address 8*idx. For example, index 3 gives 8'hDF and index 0 gives 8'hC7.
- R7: `d_oe` is high only while `rd_stb` is high inside an acknowledge window. While `d_oe` is low, `d_out` reads 8'h00.
- R8: The rising edge of `rd_stb` inside a window clears exactly the selected pending bit at that clock. If the same line rises at that same clock, the set wins and the bit stays pending.
- R9: If no request was pending and enabled when the window opened, the byte is 8'hFF and no pending bit is cleared.
- R10: A status byte with `stat_d0` low opens no window. A read that follows it leaves `d_oe` low and the pending register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Active-high request lines, edge-detected |
| irq_en | input | 8 | Per-line enable for interrupt raising and selection |
| cpu_inte | input | 1 | Processor interrupt-enable status |
| stat_stb | input | 1 | Status byte is on the bus this clock |
| stat_d0 | input | 1 | Bit 0 of the status byte, the acknowledge flag |
| rd_stb | input | 1 | Processor read strobe, active high |
| int_out | output | 1 | Interrupt request to the processor |
| d_out | output | 8 | Restart opcode towards the data bus |
| d_oe | output | 1 | Data bus drive enable; the bus is released when low |

## Verification
If a pending bit is lost or gets stuck, `int_out` shows it one clock after the request edge or the read edge that should have changed it. The next acknowledge then returns a restart byte for the wrong index. A wrong priority choice or a selection that was not frozen shows up directly in `d_out` during the same read strobe. A failed clear shows up as a repeated vector on the following acknowledge. A window that opens or stays open when it should not shows as `d_oe` being high during a plain read.

// File: rtl/rvi_pkg.sv
package rvi_pkg;
  localparam int NUM_REQ = 8;
  localparam int IDX_W   = $clog2(NUM_REQ);
  localparam int BYTE_W  = 8;

  // restart call byte: 11 iii 111 -> target address 8*iii
  function automatic logic [BYTE_W-1:0] rst_opcode(input logic [IDX_W-1:0] idx);
    logic [BYTE_W-1:0] op;
    op = 8'hC7;
    op[5:3] = idx;
    return op;
  endfunction
endpackage

// File: rtl/rvi_req_latch.sv
module rvi_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] req_q;
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    assign rise_o[i] = req_i[i] & ~req_q[i];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        req_q[i]  <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        req_q[i] <= req_i[i];
        // a fresh edge wins over a clear in the same clock
        if (rise_o[i])     pend_q[i] <= 1'b1;
        else if (clr_i[i]) pend_q[i] <= 1'b0;
      end
    end
  end

  assign pend_o = pend_q;

  // R2: pending bits only drop when cleared
  p_pend_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~$past(clr_i)) & ~pend_q) == '0);
endmodule

// File: rtl/rvi_prio_pick.sv
module rvi_prio_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  cand_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        vld_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

  // R5: nothing of higher priority below the chosen index
  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (cand_i[idx_o] && ((cand_i & ((N'(1) << idx_o) - N'(1))) == '0)));
endmodule

// File: rtl/rvi_ack_ctrl.sv
module rvi_ack_ctrl
  import rvi_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_stb,
  input  logic              stat_d0,
  input  logic              rd_stb,
  input  logic              sel_vld,
  input  logic [IW-1:0]     sel_idx,
  output logic              oe_o,
  output logic [BYTE_W-1:0] vec_o,
  output logic [N-1:0]      clr_o
);
  logic          win_q;
  logic          rd_q;
  logic          vld_q;
  logic [IW-1:0] idx_q;
  logic          rd_rise, rd_fall;

  assign rd_rise = rd_stb & ~rd_q;
  assign rd_fall = ~rd_stb & rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      rd_q  <= 1'b0;
      vld_q <= 1'b0;
      idx_q <= '0;
    end else begin
      rd_q <= rd_stb;
      if (stat_stb) begin
        win_q <= stat_d0;
        if (stat_d0) begin
          vld_q <= sel_vld;
          idx_q <= sel_idx;
        end
      end else if (rd_fall) begin
        win_q <= 1'b0;
      end
    end
  end

  always_comb begin
    clr_o = '0;
    if (win_q && rd_rise && vld_q) clr_o[idx_q] = 1'b1;
  end

  assign oe_o  = win_q & rd_stb;
  assign vec_o = vld_q ? rst_opcode(idx_q) : 8'hFF;

  // R8: at most one bit cleared per read edge
  p_one_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_o));
  // R4: choice frozen while the window stays open
  p_frozen_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && !stat_stb) |=> $stable(vec_o));
endmodule

// File: rtl/rst_vec_intc.sv
module rst_vec_intc
  import rvi_pkg::*;
#(
  parameter int N_REQ = NUM_REQ,
  localparam int IW   = $clog2(N_REQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_REQ-1:0]  irq_req,
  input  logic [N_REQ-1:0]  irq_en,
  input  logic              cpu_inte,
  input  logic              stat_stb,
  input  logic              stat_d0,
  input  logic              rd_stb,
  output logic              int_out,
  output logic [BYTE_W-1:0] d_out,
  output logic              d_oe
);
  logic [N_REQ-1:0]  pend, rise, clr, cand;
  logic              sel_vld;
  logic [IW-1:0]     sel_idx;
  logic [BYTE_W-1:0] vec;

  rvi_req_latch #(.N(N_REQ)) u_latch (
    .clk(clk), .rst_n(rst_n), .req_i(irq_req), .clr_i(clr),
    .pend_o(pend), .rise_o(rise)
  );

  assign cand = pend & irq_en;

  rvi_prio_pick #(.N(N_REQ), .IW(IW)) u_pick (
    .clk(clk), .rst_n(rst_n), .cand_i(cand), .vld_o(sel_vld), .idx_o(sel_idx)
  );

  rvi_ack_ctrl #(.N(N_REQ), .IW(IW)) u_ack (
    .clk(clk), .rst_n(rst_n), .stat_stb(stat_stb), .stat_d0(stat_d0),
    .rd_stb(rd_stb), .sel_vld(sel_vld), .sel_idx(sel_idx),
    .oe_o(d_oe), .vec_o(vec), .clr_o(clr)
  );

  assign int_out = cpu_inte & (|cand);
  assign d_out   = d_oe ? vec : '0;

  // R8: a cleared line without a new edge is gone next clock
  p_clear_takes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr != '0) && ((clr & rise) == '0)) |=> ((pend & $past(clr)) == '0));
  // R7: the bus is only driven during a read
  p_oe_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> rd_stb);
endmodule

// File: tb/rst_vec_intc_test.sv
module rst_vec_intc_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req = '0, irq_en = '0;
  logic       cpu_inte = 1'b0, stat_stb = 1'b0, stat_d0 = 1'b0, rd_stb = 1'b0;
  logic       int_out, d_oe;
  logic [7:0] d_out;

  int checks = 0, errors = 0;
  logic [7:0] model = '0;
  logic [7:0] hold = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_vec_intc uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .cpu_inte(cpu_inte), .stat_stb(stat_stb), .stat_d0(stat_d0),
    .rd_stb(rd_stb), .int_out(int_out), .d_out(d_out), .d_oe(d_oe)
  );

  function automatic int exp_idx(input logic [7:0] c);
    for (int i = 0; i < 8; i++) if (c[i]) return i;
    return 8;
  endfunction

  function automatic logic [7:0] exp_op(input int idx);
    if (idx == 8) return 8'hFF;
    return 8'hC7 | 8'(idx << 3);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_int(input string tag);
    #1 chk(tag, {7'd0, int_out}, {7'd0, cpu_inte && ((model & irq_en) != 0)});
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk) irq_req = hold | m;
    model = model | m;
    @(negedge clk) irq_req = hold;
  endtask

  // full acknowledge; extra rises together with the read strobe
  task automatic do_ack(input string tag, input logic [7:0] extra);
    int idx;
    @(negedge clk) stat_stb = 1'b1; stat_d0 = 1'b1;
    idx = exp_idx(model & irq_en);
    @(negedge clk) stat_stb = 1'b0; stat_d0 = 1'b0; rd_stb = 1'b1;
    irq_req = hold | extra;
    #1 chk({tag, " oe"}, {7'd0, d_oe}, 8'd1);
    chk({tag, " opcode"}, d_out, exp_op(idx));
    if (idx != 8) model[idx] = 1'b0;
    model = model | extra;
    @(negedge clk) rd_stb = 1'b0; irq_req = hold;
    #1 chk({tag, " oe after read R7"}, {7'd0, d_oe}, 8'd0);
    chk({tag, " idle bus R7"}, d_out, 8'd0);
    @(negedge clk);
    chk_int({tag, " int after ack"});
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    #1 chk("R1 int at reset", {7'd0, int_out}, 8'd0);
    chk("R1 oe at reset", {7'd0, d_oe}, 8'd0);
    chk("R1 data at reset", d_out, 8'd0);
    @(negedge clk) rst_n = 1'b1; irq_en = 8'hFF; cpu_inte = 1'b1;
    @(negedge clk);
    chk_int("R1 R3 empty after reset");

    // R9: nothing pending
    do_ack("R9 empty ack", 8'h00);

    // R5 R6: priority order over three requests
    pulse(8'b1010_0100);
    chk_int("R2 R3 pending raises int");
    do_ack("R5 R6 first idx2", 8'h00);
    do_ack("R5 R6 second idx5", 8'h00);
    do_ack("R5 R6 third idx7", 8'h00);

    // R3: masked and processor-disabled
    irq_en = 8'hF7;
    pulse(8'h08);
    chk_int("R3 masked stays low");
    cpu_inte = 1'b0; irq_en = 8'hFF;
    @(negedge clk) chk_int("R3 inte low gates int");
    cpu_inte = 1'b1;
    @(negedge clk) chk_int("R3 unmasked raises");

    // R10: non-acknowledge status then read
    @(negedge clk) stat_stb = 1'b1; stat_d0 = 1'b0;
    @(negedge clk) stat_stb = 1'b0; rd_stb = 1'b1;
    #1 chk("R10 no drive on plain read", {7'd0, d_oe}, 8'd0);
    @(negedge clk) rd_stb = 1'b0;
    @(negedge clk) chk_int("R10 pending kept");

    // R4: idx3 frozen although req0 rises with the read
    do_ack("R4 frozen idx3", 8'h01);
    do_ack("R4 late req0 served", 8'h00);

    // R8: same line rises at the clearing edge
    pulse(8'h10);
    do_ack("R8 clear vs set", 8'h10);
    do_ack("R8 retained idx4", 8'h00);

    // R2: held line is not re-latched
    @(negedge clk) hold = 8'h40; irq_req = hold; model = model | 8'h40;
    @(negedge clk);
    do_ack("R2 held idx6", 8'h00);
    repeat (3) @(negedge clk);
    chk_int("R2 held line not relatched");
    hold = 8'h00; irq_req = hold;

    // random mix
    for (int k = 0; k < 300; k++) begin
      irq_en = ($urandom % 4 == 0) ? 8'($urandom) : 8'hFF;
      cpu_inte = ($urandom % 5 != 0);
      if ($urandom % 2 == 0) pulse(8'($urandom) & 8'($urandom));
      @(negedge clk) chk_int("R3 random int");
      if ($urandom % 3 == 0) do_ack("R5 R6 R8 random ack", 8'h00);
    end

    finish_run();
  end
endmodule